// File: doc/BRIEF.md
# Command/Indication Change-Detect Receiver

This block watches two command/indication code fields that a time-division serial bus delivers once per frame. The fields arrive already extracted, together with a one-cycle frame strobe. A code counts as new only when it differs from the code last accepted and then holds steady over two back-to-back frames. Each accepted change is reported to a host through a readable code register, a status flag and a maskable interrupt line.

The two channels behave differently. Channel 0 sits behind a queue of two entries. The first change goes straight to the visible register. Later changes collect in a single held slot, and each new change overwrites that slot, so the host reads the first change and then the newest one, and the codes in between are lost. The flag stays up across the read that brings the held code forward. Channel 1 has no queue: its register always shows the code most recently accepted. Its flag can be switched off while the register keeps tracking the bus.

Top module: `ci_change_rx`

## Requirements
- R1: After reset, `code0` is all ones (4'hF), `code1` is all ones (6'h3F), `chg0_flag`, `chg1_flag` and `irq` are 0, and the channel 0 held slot is empty.
- R2: A code is accepted only on a frame strobe where the input equals the input of the previous strobe and differs from the code already accepted. A value that appears for a single frame changes nothing.
- R3: When the channel 0 flag is clear, an accepted channel 0 change loads `code0` and sets `chg0_flag` on the clock edge that samples the strobe.
- R4: While `chg0_flag` is set, an accepted channel 0 change goes into the held slot and leaves `code0` unchanged. A `rd_ch0` pulse with a held code loads that code into `code0` on its edge, and `chg0_flag` stays 1.
- R5: With several channel 0 changes before a read, `code0` shows the first one, and the read brings forward only the most recent one. The codes in between are discarded.
- R6: A `rd_ch0` pulse with `chg0_flag` set and no held code clears `chg0_flag`. The read does not change `code0`.
- R7: `code1` takes every accepted channel 1 code on the edge that samples the strobe. With `ch1_flag_en`=1 that change sets `chg1_flag`, and a `rd_ch1` pulse clears it.
- R8: With `ch1_flag_en`=0, `code1` still tracks accepted codes, but `chg1_flag` is never set.
- R9: `irq` is registered. One edge after the flags change, it equals (`chg0_flag` AND NOT `mask_ch0`) OR (`chg1_flag` AND NOT `mask_ch1`). Masking has no effect on flags, codes or held codes.
- R10: When a read and an accepted change fall in the same cycle, the change wins. On channel 0 the new code goes into `code0`, any held code is dropped, and `chg0_flag` stays 1. On channel 1 `chg1_flag` is set if enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe: the code fields are valid |
| code0_in | input | 4 | Received channel 0 code |
| code1_in | input | 6 | Received channel 1 code |
| rd_ch0 | input | 1 | Host read of `code0` |
| rd_ch1 | input | 1 | Host read of `code1` |
| ch1_flag_en | input | 1 | Enables the channel 1 change flag |
| mask_ch0 | input | 1 | 1 masks channel 0 from `irq` |
| mask_ch1 | input | 1 | 1 masks channel 1 from `irq` |
| code0 | output | 4 | Channel 0 code register |
| code1 | output | 6 | Channel 1 code register |
| chg0_flag | output | 1 | Channel 0 change pending |
| chg1_flag | output | 1 | Channel 1 change pending |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest state to reach is a held channel 0 slot that is overwritten several times and is then hit by a read in the same cycle as yet another accepted change. Reaching it takes two matching strobes per change while the host stays silent. Directed sequences build that exact sequence of changes and then line up a strobe with `rd_ch0`. Long random runs draw codes from a small alphabet, so stable repeats and one-frame glitches both occur often, and reads come at random points.

// File: rtl/ci_rx_pkg.sv
package ci_rx_pkg;
  localparam int CI0_W_DEF = 4;
  localparam int CI1_W_DEF = 6;

  // channel 0 queue occupancy
  typedef enum logic [1:0] {
    Q_EMPTY = 2'd0,  // no change pending
    Q_SHOWN = 2'd1,  // change in visible register
    Q_HELD  = 2'd2   // visible register plus one held code
  } q_state_e;
endpackage

// File: rtl/ci_stable_detect.sv
module ci_stable_detect #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic         evt,
  output logic [W-1:0] evt_code
);
  logic [W-1:0] last_q;
  logic [W-1:0] acc_q;

  assign evt      = stb && (din == last_q) && (din != acc_q);
  assign evt_code = din;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '1;
      acc_q  <= '1;
    end else if (stb) begin
      last_q <= din;
      if (evt) acc_q <= din;
    end
  end

  AST_GLITCH_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (stb && din != last_q) |=> $stable(acc_q)); // R2
endmodule

// File: rtl/ci0_queue.sv
module ci0_queue
  import ci_rx_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt,
  input  logic [W-1:0] evt_code,
  input  logic         rd,
  output logic [W-1:0] code,
  output logic         flag
);
  q_state_e     st_q;
  logic [W-1:0] code_q;
  logic [W-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= Q_EMPTY;
      code_q <= '1;
      pend_q <= '1;
      flag   <= 1'b0;
    end else begin
      if (evt) begin
        if (st_q == Q_EMPTY || rd) begin
          code_q <= evt_code;
          st_q   <= Q_SHOWN;
        end else begin
          pend_q <= evt_code;
          st_q   <= Q_HELD;
        end
        flag <= 1'b1;
      end else if (rd) begin
        if (st_q == Q_HELD) begin
          code_q <= pend_q;
          st_q   <= Q_SHOWN;
        end else begin
          st_q <= Q_EMPTY;
          flag <= 1'b0;
        end
      end
    end
  end

  assign code = code_q;

  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (rst)
    (evt && st_q == Q_EMPTY) |=> (flag && code == $past(evt_code))); // R3
  AST_READ_PROMOTES: assert property (@(posedge clk) disable iff (rst)
    (rd && !evt && st_q == Q_HELD) |=> (flag && code == $past(pend_q))); // R4
  AST_HELD_KEEPS_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (evt && !rd && st_q != Q_EMPTY) |=> $stable(code)); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd && !evt && st_q == Q_SHOWN) |=> !flag); // R6
  AST_COLLIDE_NEWEST: assert property (@(posedge clk) disable iff (rst)
    (rd && evt) |=> (flag && code == $past(evt_code))); // R10
endmodule

// File: rtl/ci1_reg.sv
module ci1_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt,
  input  logic [W-1:0] evt_code,
  input  logic         rd,
  input  logic         en,
  output logic [W-1:0] code,
  output logic         flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '1;
      flag <= 1'b0;
    end else begin
      if (evt) code <= evt_code;
      if (evt && en)  flag <= 1'b1;
      else if (rd)    flag <= 1'b0;
    end
  end

  AST_CH1_TRACKS: assert property (@(posedge clk) disable iff (rst)
    evt |=> (code == $past(evt_code))); // R7
  AST_CH1_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !flag) |=> !flag); // R8
endmodule

// File: rtl/ci_change_rx.sv
module ci_change_rx
  import ci_rx_pkg::*;
#(
  parameter int CI0_W = CI0_W_DEF,
  parameter int CI1_W = CI1_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  input  logic [CI0_W-1:0] code0_in,
  input  logic [CI1_W-1:0] code1_in,
  input  logic             rd_ch0,
  input  logic             rd_ch1,
  input  logic             ch1_flag_en,
  input  logic             mask_ch0,
  input  logic             mask_ch1,
  output logic [CI0_W-1:0] code0,
  output logic [CI1_W-1:0] code1,
  output logic             chg0_flag,
  output logic             chg1_flag,
  output logic             irq
);
  logic             evt0, evt1;
  logic [CI0_W-1:0] evt0_code;
  logic [CI1_W-1:0] evt1_code;

  ci_stable_detect #(.W(CI0_W)) u_det0 (
    .clk(clk), .rst(rst), .stb(frame_stb), .din(code0_in),
    .evt(evt0), .evt_code(evt0_code));

  ci_stable_detect #(.W(CI1_W)) u_det1 (
    .clk(clk), .rst(rst), .stb(frame_stb), .din(code1_in),
    .evt(evt1), .evt_code(evt1_code));

  ci0_queue #(.W(CI0_W)) u_q0 (
    .clk(clk), .rst(rst), .evt(evt0), .evt_code(evt0_code),
    .rd(rd_ch0), .code(code0), .flag(chg0_flag));

  ci1_reg #(.W(CI1_W)) u_r1 (
    .clk(clk), .rst(rst), .evt(evt1), .evt_code(evt1_code),
    .rd(rd_ch1), .en(ch1_flag_en), .code(code1), .flag(chg1_flag));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (chg0_flag & ~mask_ch0) | (chg1_flag & ~mask_ch1);
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(chg0_flag) && !mask_ch0) |=> irq); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!chg0_flag && !chg1_flag) |=> !irq); // R9
endmodule

// File: tb/ci_change_rx_bench.sv
module ci_change_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_stb = 0, rd_ch0 = 0, rd_ch1 = 0;
  logic       ch1_flag_en = 1, mask_ch0 = 0, mask_ch1 = 0;
  logic [3:0] code0_in = 4'hF;
  logic [5:0] code1_in = 6'h3F;
  logic [3:0] code0;
  logic [5:0] code1;
  logic       chg0_flag, chg1_flag, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [3:0] m_l0, m_a0, m_c0, m_pc;
  logic [5:0] m_l1, m_a1, m_c1;
  logic       m_f0, m_pv, m_f1, m_irq;

  always #10 clk = ~clk;

  ci_change_rx u_ci_change_rx (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .code0_in(code0_in),
    .code1_in(code1_in), .rd_ch0(rd_ch0), .rd_ch1(rd_ch1),
    .ch1_flag_en(ch1_flag_en), .mask_ch0(mask_ch0), .mask_ch1(mask_ch1),
    .code0(code0), .code1(code1), .chg0_flag(chg0_flag),
    .chg1_flag(chg1_flag), .irq(irq));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_l0 = 4'hF; m_a0 = 4'hF; m_c0 = 4'hF; m_pc = 4'hF;
    m_l1 = 6'h3F; m_a1 = 6'h3F; m_c1 = 6'h3F;
    m_f0 = 0; m_pv = 0; m_f1 = 0; m_irq = 0;
  endtask

  task automatic model_edge();
    logic e0, e1, irq_n;
    irq_n = (m_f0 & ~mask_ch0) | (m_f1 & ~mask_ch1);
    e0 = frame_stb && code0_in == m_l0 && code0_in != m_a0;
    e1 = frame_stb && code1_in == m_l1 && code1_in != m_a1;
    if (frame_stb) begin
      m_l0 = code0_in; m_l1 = code1_in;
      if (e0) m_a0 = code0_in;
      if (e1) m_a1 = code1_in;
    end
    if (e0) begin
      if (!m_f0 || rd_ch0) begin m_c0 = code0_in; m_pv = 0; end
      else begin m_pc = code0_in; m_pv = 1; end
      m_f0 = 1;
    end else if (rd_ch0 && m_f0) begin
      if (m_pv) begin m_c0 = m_pc; m_pv = 0; end
      else m_f0 = 0;
    end
    if (e1) m_c1 = code1_in;
    if (e1 && ch1_flag_en) m_f1 = 1;
    else if (rd_ch1) m_f1 = 0;
    m_irq = irq_n;
  endtask

  task automatic compare_all();
    check("R4 code0", code0, m_c0);
    check("R6 chg0_flag", chg0_flag, m_f0);
    check("R7 code1", code1, m_c1);
    check("R8 chg1_flag", chg1_flag, m_f1);
    check("R9 irq", irq, m_irq);
  endtask

  // one clock: inputs driven at negedge, outputs compared at next negedge
  task automatic cyc(bit s, logic [3:0] c0, logic [5:0] c1, bit r0, bit r1);
    frame_stb = s; code0_in = c0; code1_in = c1; rd_ch0 = r0; rd_ch1 = r1;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    frame_stb = 0; rd_ch0 = 0; rd_ch1 = 0;
    compare_all();
  endtask

  task automatic frame(logic [3:0] c0, logic [5:0] c1);
    cyc(1, c0, c1, 0, 0);
    cyc(0, c0, c1, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 code0", code0, 4'hF);
    check("R1 code1", code1, 6'h3F);
    check("R1 flags", {chg0_flag, chg1_flag, irq}, 0);

    // R2 single-frame glitch, then stable value
    frame(4'h3, 6'h3F);
    check("R2 glitch ignored", code0, 4'hF);
    frame(4'h5, 6'h3F);
    check("R2 one frame not enough", chg0_flag, 0);
    frame(4'h5, 6'h3F);
    check("R3 first change", code0, 4'h5);
    check("R3 flag set", chg0_flag, 1);

    // R5 several changes: first kept visible, newest held
    frame(4'h9, 6'h3F); frame(4'h9, 6'h3F);
    frame(4'hA, 6'h3F); frame(4'hA, 6'h3F);
    frame(4'hC, 6'h3F); frame(4'hC, 6'h3F);
    check("R5 first still visible", code0, 4'h5);
    cyc(0, 4'hC, 6'h3F, 1, 0);
    check("R5 newest after read", code0, 4'hC);
    check("R4 flag stays", chg0_flag, 1);
    cyc(0, 4'hC, 6'h3F, 1, 0);
    check("R6 flag cleared", chg0_flag, 0);
    check("R6 code kept", code0, 4'hC);

    // R10 read coinciding with a change
    frame(4'h2, 6'h3F); frame(4'h2, 6'h3F);
    frame(4'h8, 6'h3F); frame(4'h8, 6'h3F); // held 8
    cyc(1, 4'h7, 6'h3F, 0, 0);
    cyc(1, 4'h7, 6'h3F, 1, 0);
    check("R10 newest wins", code0, 4'h7);
    check("R10 flag set", chg0_flag, 1);
    cyc(0, 4'h7, 6'h3F, 1, 0);
    check("R10 no stale held", chg0_flag, 0);

    // R8 channel 1 flag disabled
    ch1_flag_en = 0;
    frame(4'h7, 6'h15); frame(4'h7, 6'h15);
    check("R8 code tracks", code1, 6'h15);
    check("R8 no flag", chg1_flag, 0);
    ch1_flag_en = 1;
    frame(4'h7, 6'h2A); frame(4'h7, 6'h2A);
    check("R7 code1", code1, 6'h2A);
    check("R7 flag set", chg1_flag, 1);
    mask_ch1 = 1;
    cyc(0, 4'h7, 6'h2A, 0, 0); cyc(0, 4'h7, 6'h2A, 0, 0);
    check("R9 masked", irq, 0);
    check("R9 flag kept", chg1_flag, 1);
    mask_ch1 = 0;
    cyc(0, 4'h7, 6'h2A, 0, 0); cyc(0, 4'h7, 6'h2A, 0, 0);
    check("R9 unmasked", irq, 1);
    cyc(0, 4'h7, 6'h2A, 0, 1);
    check("R7 read clears", chg1_flag, 0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 50 == 0) ch1_flag_en = ~ch1_flag_en;
      if ($urandom % 40 == 0) mask_ch0 = ~mask_ch0;
      if ($urandom % 40 == 0) mask_ch1 = ~mask_ch1;
      cyc(($urandom % 3) == 0, 4'($urandom % 4), 6'($urandom % 4),
          ($urandom % 6) == 0, ($urandom % 6) == 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule